// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer

This block holds the interrupt enable bits of a 16550-style serial port and reduces all interrupt sources to one identification value and one level interrupt line. The rest of the port (FIFOs, serializers, baud generator, modem-line sampler) feeds in its status: sticky-error events, parity and framing levels, data-ready, receive FIFO fill count and trigger level, a character-timeout pending level, the transmit-holding-empty level and the modem delta bits. Register access strobes tell the block when software writes the enable register or the transmit holding register, and when it reads the identification or line-status register.

The block keeps three pieces of state of its own. The first is the enable nibble. The second is a pending flag for the transmit-empty source, which reading the identification register can acknowledge. The third is the sticky break and overrun bits, which a line-status read clears. Everything else is combinational from the status inputs. Only one source is reported at a time, picked by fixed priority.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable nibble is 0, the transmit-empty pending flag and the sticky break and overrun bits are 0, `iir_o` reads 0x01 with FIFOs off, and `irq_o` is low.
- R2: A pulse on `ier_wr_i` stores `ier_wdata_i[3:0]` into `ier_o` at the next rising edge. Bits 7:4 of the write data are dropped. Enable bit 0 is receive data, bit 1 is transmit empty, bit 2 is line status and bit 3 is modem status.
- R3: The identification code in `iir_o[3:0]` comes from the highest active source, in this order: line status 0x6, character timeout 0xC, received data 0x4, transmit empty 0x2, modem status 0x0.
- R4: The line-status source is active when enable bit 2 is set and any bit of `err_o` is set. `err_o` is ordered {break, framing, parity, overrun}.
- R5: The character-timeout source is active when `timeout_i` is high and enable bit 0 is set. It has no enable bit of its own.
- R6: The received-data source is active when enable bit 0 and `data_ready_i` are set, and either `fifo_en_i` is low or `rx_count_i` >= `rx_trig_i`.
- R7: With no active source, `iir_o[3:0]` is 0x1 and `irq_o` is low. With any active source, `iir_o[0]` is 0 and `irq_o` is high.
- R8: `iir_o[7:6]` is 2'b11 while `fifo_en_i` is high and 2'b00 otherwise. `iir_o[5:4]` is 0.
- R9: An identification read whose returned code is 0x2 clears the transmit-empty pending flag.
- R10: An enable write that changes bit 1 sets the pending flag to (new bit 1 AND `thr_empty_i`). An enable write that leaves bit 1 unchanged keeps the flag.
- R11: Each of these changes the pending flag, listed from highest precedence: `xmit_rst_i` sets it, then `thr_wr_i` clears it, then a rising edge of `thr_empty_i` sets it, then R10, then R9.
- R12: `brk_evt_i` and `ovr_evt_i` set sticky bits. A `lsr_rd_i` pulse clears both unless the same cycle carries a new event, which wins. The framing and parity bits of `err_o` follow `fe_i` and `pe_i` directly.
- R13: The modem-status source is active when enable bit 3 is set and any bit of `msr_delta_i` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_wr_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| xmit_rst_i | input | 1 | Transmit FIFO reset strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| lsr_rd_i | input | 1 | Line-status register read strobe |
| brk_evt_i | input | 1 | Break received event |
| ovr_evt_i | input | 1 | Receive overrun event |
| fe_i | input | 1 | Framing error level |
| pe_i | input | 1 | Parity error level |
| data_ready_i | input | 1 | Receive data ready |
| fifo_en_i | input | 1 | FIFOs enabled |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_trig_i | input | CNT_W | Receive trigger level |
| timeout_i | input | 1 | Character timeout pending |
| thr_empty_i | input | 1 | Transmit holding register empty |
| msr_delta_i | input | 4 | Modem status delta bits |
| ier_o | output | 4 | Stored enable nibble |
| err_o | output | 4 | Line error bits {break, framing, parity, overrun} |
| iir_o | output | 8 | Identification register value |
| irq_o | output | 1 | Interrupt request, level |

## Verification
A corrupted pending flag or sticky bit shows on `iir_o` and `irq_o` in the same cycle in which that source becomes the highest enabled one. If a higher source is active at that moment, it hides the fault until that source goes away. A wrong enable nibble shows on `ier_o` one cycle after the write. Wrong priority logic shows combinationally on the first cycle in which two sources overlap. The stimulus therefore holds many sources active together, so that each masking relation is exercised.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    ID_MDM  = 4'h0,
    ID_NONE = 4'h1,
    ID_THR  = 4'h2,
    ID_RXD  = 4'h4,
    ID_LINE = 4'h6,
    ID_TMO  = 4'hC
  } irq_id_e;

  localparam int EN_RXD  = 0;
  localparam int EN_THR  = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;
  localparam int EN_W    = 4;
endpackage

// File: rtl/uart_irq_flags.sv
module uart_irq_flags
  import uart_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ier_wr_i,
  input  logic [7:0]      ier_wdata_i,
  input  logic            thr_wr_i,
  input  logic            xmit_rst_i,
  input  logic            thr_empty_i,
  input  logic            iir_rd_i,
  input  logic            thri_shown_i,
  input  logic            lsr_rd_i,
  input  logic            brk_evt_i,
  input  logic            ovr_evt_i,
  output logic [EN_W-1:0] ier_o,
  output logic            thr_pend_o,
  output logic            brk_o,
  output logic            ovr_o
);
  logic [EN_W-1:0] ier_q;
  logic thr_pend_q, empty_q, brk_q, ovr_q;
  logic thr_pend_d;
  logic empty_rise, thri_toggle;

  assign empty_rise  = thr_empty_i && !empty_q;
  assign thri_toggle = ier_wr_i && (ier_wdata_i[EN_THR] != ier_q[EN_THR]);

  always_comb begin
    thr_pend_d = thr_pend_q;
    if (xmit_rst_i)                    thr_pend_d = 1'b1;
    else if (thr_wr_i)                 thr_pend_d = 1'b0;
    else if (empty_rise)               thr_pend_d = 1'b1;
    else if (thri_toggle)              thr_pend_d = ier_wdata_i[EN_THR] && thr_empty_i;
    else if (iir_rd_i && thri_shown_i) thr_pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q      <= '0;
      thr_pend_q <= 1'b0;
      empty_q    <= 1'b1;
      brk_q      <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      if (ier_wr_i) ier_q <= ier_wdata_i[EN_W-1:0];
      thr_pend_q <= thr_pend_d;
      empty_q    <= thr_empty_i;
      if (brk_evt_i)     brk_q <= 1'b1;
      else if (lsr_rd_i) brk_q <= 1'b0;
      if (ovr_evt_i)     ovr_q <= 1'b1;
      else if (lsr_rd_i) ovr_q <= 1'b0;
    end
  end

  assign ier_o      = ier_q;
  assign thr_pend_o = thr_pend_q;
  assign brk_o      = brk_q;
  assign ovr_o      = ovr_q;

  assert_ier_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_wr_i |=> ier_q == $past(ier_wdata_i[EN_W-1:0]));
  assert_xrst_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xmit_rst_i |=> thr_pend_q);
  assert_thr_wr_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_wr_i && !xmit_rst_i) |=> !thr_pend_q);
  assert_iir_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && thri_shown_i && !xmit_rst_i && !empty_rise && !ier_wr_i) |=> !thr_pend_q);
  assert_brk_clr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !brk_evt_i) |=> !brk_q);
  assert_ovr_clr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !ovr_evt_i) |=> !ovr_q);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [EN_W-1:0]  ier_i,
  input  logic [3:0]       err_i,
  input  logic             timeout_i,
  input  logic             data_ready_i,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             thr_pend_i,
  input  logic [3:0]       msr_delta_i,
  output irq_id_e          id_o
);
  logic line_act, tmo_act, rxd_act, thr_act, mdm_act;

  assign line_act = ier_i[EN_LINE] && (|err_i);
  assign tmo_act  = ier_i[EN_RXD] && timeout_i;
  assign rxd_act  = ier_i[EN_RXD] && data_ready_i && (!fifo_en_i || (rx_count_i >= rx_trig_i));
  assign thr_act  = ier_i[EN_THR] && thr_pend_i;
  assign mdm_act  = ier_i[EN_MDM] && (|msr_delta_i);

  always_comb begin
    if (line_act)     id_o = ID_LINE;
    else if (tmo_act) id_o = ID_TMO;
    else if (rxd_act) id_o = ID_RXD;
    else if (thr_act) id_o = ID_THR;
    else if (mdm_act) id_o = ID_MDM;
    else              id_o = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ier_wr_i,
  input  logic [7:0]       ier_wdata_i,
  input  logic             thr_wr_i,
  input  logic             xmit_rst_i,
  input  logic             iir_rd_i,
  input  logic             lsr_rd_i,
  input  logic             brk_evt_i,
  input  logic             ovr_evt_i,
  input  logic             fe_i,
  input  logic             pe_i,
  input  logic             data_ready_i,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             timeout_i,
  input  logic             thr_empty_i,
  input  logic [3:0]       msr_delta_i,
  output logic [EN_W-1:0]  ier_o,
  output logic [3:0]       err_o,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  logic [EN_W-1:0] ier_w;
  logic thr_pend_w, brk_w, ovr_w;
  irq_id_e id_w;

  uart_irq_flags u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ier_wr_i     (ier_wr_i),
    .ier_wdata_i  (ier_wdata_i),
    .thr_wr_i     (thr_wr_i),
    .xmit_rst_i   (xmit_rst_i),
    .thr_empty_i  (thr_empty_i),
    .iir_rd_i     (iir_rd_i),
    .thri_shown_i (id_w == ID_THR),
    .lsr_rd_i     (lsr_rd_i),
    .brk_evt_i    (brk_evt_i),
    .ovr_evt_i    (ovr_evt_i),
    .ier_o        (ier_w),
    .thr_pend_o   (thr_pend_w),
    .brk_o        (brk_w),
    .ovr_o        (ovr_w)
  );

  assign err_o = {brk_w, fe_i, pe_i, ovr_w};

  uart_irq_prio #(.CNT_W(CNT_W)) u_prio (
    .ier_i        (ier_w),
    .err_i        (err_o),
    .timeout_i    (timeout_i),
    .data_ready_i (data_ready_i),
    .fifo_en_i    (fifo_en_i),
    .rx_count_i   (rx_count_i),
    .rx_trig_i    (rx_trig_i),
    .thr_pend_i   (thr_pend_w),
    .msr_delta_i  (msr_delta_i),
    .id_o         (id_w)
  );

  assign iir_o = {fifo_en_i, fifo_en_i, 2'b00, id_w};
  assign irq_o = (id_w != ID_NONE);
  assign ier_o = ier_w;

  assert_line_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_w[EN_LINE] && (|err_o)) |-> iir_o[3:0] == 4'h6);
  assert_tmo_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ier_w[EN_RXD] |-> iir_o[3:0] != 4'hC);
  assert_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_w == '0) |-> (!irq_o && iir_o[0]));
endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;

  logic clk = 0, rst_n = 0;
  logic ier_wr = 0, thr_wr = 0, xrst = 0, iir_rd = 0, lsr_rd = 0, brk_evt = 0, ovr_evt = 0;
  logic [7:0] ier_wdata = 0;
  logic fe = 0, pe = 0, dr = 0, fifo_en = 0, tmo = 0, thr_empty = 1;
  logic [CNT_W-1:0] rx_count = 0, rx_trig = 1;
  logic [3:0] msr_delta = 0;
  logic [3:0] ier_o, err_o;
  logic [7:0] iir_o;
  logic irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [3:0] m_ier;
  logic m_pend, m_brk, m_ovr, m_empty;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident #(.CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ier_wr_i(ier_wr), .ier_wdata_i(ier_wdata),
    .thr_wr_i(thr_wr), .xmit_rst_i(xrst), .iir_rd_i(iir_rd), .lsr_rd_i(lsr_rd),
    .brk_evt_i(brk_evt), .ovr_evt_i(ovr_evt), .fe_i(fe), .pe_i(pe),
    .data_ready_i(dr), .fifo_en_i(fifo_en), .rx_count_i(rx_count), .rx_trig_i(rx_trig),
    .timeout_i(tmo), .thr_empty_i(thr_empty), .msr_delta_i(msr_delta),
    .ier_o(ier_o), .err_o(err_o), .iir_o(iir_o), .irq_o(irq_o));

  function automatic logic [3:0] exp_err();
    return {m_brk, fe, pe, m_ovr};
  endfunction

  function automatic logic [3:0] exp_code();
    if (m_ier[2] && (|exp_err())) return 4'h6;
    if (m_ier[0] && tmo) return 4'hC;
    if (m_ier[0] && dr && (!fifo_en || rx_count >= rx_trig)) return 4'h4;
    if (m_ier[1] && m_pend) return 4'h2;
    if (m_ier[3] && (|msr_delta)) return 4'h0;
    return 4'h1;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [3:0] c;
    c = exp_code();
    chk("R3 code", {4'h0, iir_o[3:0]}, {4'h0, c});
    chk("R7 irq", {7'h0, irq_o}, {7'h0, c != 4'h1});
    chk("R8 fifo bits", {iir_o[7:4], 4'h0}, {fifo_en, fifo_en, 2'b00, 4'h0});
    chk("R2 ier", {4'h0, ier_o}, {4'h0, m_ier});
    chk("R12 err", {4'h0, err_o}, {4'h0, exp_err()});
  endtask

  // check, advance one edge, update model, clear strobes
  task automatic step();
    logic [3:0] c, n_ier;
    logic n_pend, n_brk, n_ovr;
    #1;
    check_all();
    c = exp_code();
    n_ier = ier_wr ? ier_wdata[3:0] : m_ier;
    n_pend = m_pend;
    if (xrst) n_pend = 1;
    else if (thr_wr) n_pend = 0;
    else if (thr_empty && !m_empty) n_pend = 1;
    else if (ier_wr && (ier_wdata[1] != m_ier[1])) n_pend = ier_wdata[1] && thr_empty;
    else if (iir_rd && c == 4'h2) n_pend = 0;
    n_brk = brk_evt ? 1'b1 : (lsr_rd ? 1'b0 : m_brk);
    n_ovr = ovr_evt ? 1'b1 : (lsr_rd ? 1'b0 : m_ovr);
    @(posedge clk);
    #1;
    m_ier = n_ier; m_pend = n_pend; m_brk = n_brk; m_ovr = n_ovr; m_empty = thr_empty;
    ier_wr = 0; thr_wr = 0; xrst = 0; iir_rd = 0; lsr_rd = 0; brk_evt = 0; ovr_evt = 0;
  endtask

  task automatic expect_code(string tag, logic [3:0] exp);
    #1;
    chk(tag, {4'h0, iir_o[3:0]}, {4'h0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5a17);
    m_ier = 0; m_pend = 0; m_brk = 0; m_ovr = 0; m_empty = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 iir", iir_o, 8'h01);
    chk("R1 irq", {7'h0, irq_o}, 8'h0);
    chk("R1 ier", {4'h0, ier_o}, 8'h0);
    chk("R1 err", {4'h0, err_o}, 8'h0);

    // R10 enabling transmit empty while empty samples the flag; upper data bits dropped (R2)
    ier_wr = 1; ier_wdata = 8'hFF; step();
    chk("R2 upper dropped", {4'h0, ier_o}, 8'h0F);
    expect_code("R10 resample", 4'h2);
    // R9 identification read acknowledges it
    iir_rd = 1; step();
    expect_code("R9 ack", 4'h1);
    // R13 modem delta
    msr_delta = 4'b0010; step();
    expect_code("R13 modem", 4'h0);
    // R11 write clears, empty rising sets
    thr_empty = 0; thr_wr = 1; step();
    expect_code("R11 thr write", 4'h0);
    thr_empty = 1; step();
    expect_code("R11 empty rise", 4'h2);
    // R6 trigger level
    dr = 1; fifo_en = 1; rx_trig = 4; rx_count = 3; step();
    expect_code("R6 below trig", 4'h2);
    rx_count = 4; step();
    expect_code("R6 at trig", 4'h4);
    fifo_en = 0; rx_count = 0; step();
    expect_code("R6 fifo off", 4'h4);
    chk("R8 bits off", {iir_o[7:6], 6'h0}, 8'h00);
    fifo_en = 1; step();
    chk("R8 bits on", {iir_o[7:6], 6'h0}, 8'hC0);
    // R5 timeout above rx, gated by bit 0
    tmo = 1; step();
    expect_code("R5 timeout", 4'hC);
    ier_wr = 1; ier_wdata = 8'h0E; step();
    expect_code("R5 gated", 4'h2);
    // R4 line status on top; R12 read clears break
    brk_evt = 1; step();
    expect_code("R4 break", 4'h6);
    chk("R12 brk set", {4'h0, err_o}, 8'h08);
    lsr_rd = 1; ovr_evt = 1; step();
    chk("R12 ovr wins", {4'h0, err_o}, 8'h01);
    lsr_rd = 1; step();
    chk("R12 cleared", {4'h0, err_o}, 8'h00);
    pe = 1; step();
    expect_code("R4 parity", 4'h6);
    ier_wr = 1; ier_wdata = 8'h0A; step();
    expect_code("R4 masked", 4'h2);
    // R11 transmit reset sets, R10 disable clears
    ier_wr = 1; ier_wdata = 8'h08; step();
    ier_wr = 1; ier_wdata = 8'h0A; thr_empty = 0; step();
    expect_code("R10 not empty", 4'h0);
    xrst = 1; step();
    expect_code("R11 xmit reset", 4'h2);

    // constrained random phase
    for (int i = 0; i < 3000; i++) begin
      ier_wr   = ($urandom % 6) == 0;
      ier_wdata = 8'($urandom);
      thr_wr   = ($urandom % 8) == 0;
      xrst     = ($urandom % 16) == 0;
      iir_rd   = ($urandom % 3) == 0;
      lsr_rd   = ($urandom % 5) == 0;
      brk_evt  = ($urandom % 12) == 0;
      ovr_evt  = ($urandom % 12) == 0;
      if (($urandom % 4) == 0) begin fe = 1'($urandom); pe = ($urandom % 5) == 0; end
      if (($urandom % 3) == 0) thr_empty = 1'($urandom);
      dr = 1'($urandom);
      fifo_en = ($urandom % 4) != 0;
      rx_count = CNT_W'($urandom % 17);
      rx_trig = CNT_W'(1 + $urandom % 14);
      tmo = ($urandom % 6) == 0;
      msr_delta = ($urandom % 3) == 0 ? 4'($urandom) : 4'h0;
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule